// File: doc/BRIEF.md
# GPIO Pin Event Interrupt and Wakeup Controller

This block watches fourteen general-purpose input pins and turns their activity into per-pin pending flags. Software configures it over a simple register bus. Each pin has its own settings for edge or level sensing, for active polarity and for catching both edges. It also has an interrupt enable and a wake enable. Pin inputs pass through a two-flop synchronizer. An edge is found by comparing the synchronized value with a registered copy from the previous cycle.

A flag is set by its pin's configured event whatever the enable bits say. The flag stays set until software writes a one to the matching bit of the write-one-to-clear register. Changing the enable never removes a flag. The interrupt output is the OR over all pins of flag AND interrupt enable. The wakeup output is the OR over all pins of flag AND wake enable. The low-power sequencer uses the wakeup output.

The bus is a single-cycle strobe: a write takes effect on the clock edge where `busSel` and `busWrite` are both high. Read data is combinational from `busAddr`.

Top module: `pin_irq_wake_ctrl`

## Requirements
- R1: After reset every configuration register and every pending flag is zero, and `irqOut` and `wakeOut` are low, provided all pins are low.
- R2: The registers sit at these byte offsets: mode 0x2C, polarity 0x30, interrupt enable 0x34, wake enable 0x4C and dual edge 0x5C. Each is read/write in bits 13:0, with bit n belonging to pin n. Bits 31:14 read as zero whatever is written to them.
- R3: The pending-flag register at offset 0x40 is read-only. A write to it leaves the flags unchanged.
- R4: A write to the clear register at offset 0x48 clears every flag whose data bit is 1 and leaves flags whose data bit is 0 untouched. The clear register reads as zero. A flag falls only through such a write.
- R5: When a pin's event and a clear of its flag occur in the same cycle, the flag stays set.
- R6: In edge mode (mode bit 1) with the dual-edge bit 0, polarity 0 selects the rising edge and polarity 1 selects the falling edge. The opposite edge sets nothing.
- R7: In edge mode with the dual-edge bit 1, both edges set the flag and the polarity bit has no effect. In level mode the dual-edge bit has no effect.
- R8: In level mode (mode bit 0), the flag is set on every cycle in which the synchronized pin is at its active level: high for polarity 0, low for polarity 1. A clear written while the level persists therefore leaves the flag set.
- R9: Flags are set whether or not the pin's interrupt enable is set. Clearing an enable bit does not clear the flag.
- R10: `irqOut` equals the OR over all pins of flag AND interrupt enable.
- R11: `wakeOut` equals the OR over all pins of flag AND wake enable, independently of the interrupt enables.
- R12: A pin change applied before clock edge k shows in the flag after edge k+2 and not before, because of the two synchronizer stages and one detect stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data |
| pinIn | input | 14 | Asynchronous pin inputs |
| irqOut | output | 1 | Combined interrupt request |
| wakeOut | output | 1 | Combined wakeup request |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as a fresh event. The bench reaches it with level mode: it holds a pin at its active level and writes the clear, so the event is present on the very clock edge where the clear strobe is taken. A sweep over every pin crosses all eight combinations of mode, polarity and dual edge, and drives both transitions. It samples one cycle early to pin down the synchronizer latency. Separate sweeps of one-hot enable and wake masks over a fixed flag pattern check the two output reductions.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_MODE = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_POL  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_EN   = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_WAKE = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_DUAL = 8'h5C;

  typedef struct packed {
    logic wrMode;
    logic wrPol;
    logic wrEn;
    logic wrClr;
    logic wrWake;
    logic wrDual;
  } regStrobe_t;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int WIDTH  = 14,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinAsync,
  output logic [WIDTH-1:0] syncVal,
  output logic [WIDTH-1:0] prevVal
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= pinAsync;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVal <= '0;
    else       prevVal <= chain[STAGES-1];
  end

  assign syncVal = chain[STAGES-1];
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 14
) (
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [NUM_PINS-1:0] cfgMode,
  input  logic [NUM_PINS-1:0] cfgPol,
  input  logic [NUM_PINS-1:0] cfgEn,
  input  logic [NUM_PINS-1:0] cfgWake,
  input  logic [NUM_PINS-1:0] cfgDual,
  input  logic [NUM_PINS-1:0] flags,
  output regStrobe_t          strobe,
  output logic [NUM_PINS-1:0] wrData,
  output logic [DATA_W-1:0]   busRdata
);
  localparam int PAD_W = DATA_W - NUM_PINS;

  logic                wrHit;
  logic [NUM_PINS-1:0] rdField;

  assign wrHit  = busSel & busWrite;
  assign wrData = busWdata[NUM_PINS-1:0];

  always_comb begin
    strobe        = '0;
    strobe.wrMode = wrHit && (busAddr == OFS_MODE);
    strobe.wrPol  = wrHit && (busAddr == OFS_POL);
    strobe.wrEn   = wrHit && (busAddr == OFS_EN);
    strobe.wrClr  = wrHit && (busAddr == OFS_CLR);
    strobe.wrWake = wrHit && (busAddr == OFS_WAKE);
    strobe.wrDual = wrHit && (busAddr == OFS_DUAL);
  end

  always_comb begin
    unique case (busAddr)
      OFS_MODE: rdField = cfgMode;
      OFS_POL:  rdField = cfgPol;
      OFS_EN:   rdField = cfgEn;
      OFS_FLAG: rdField = flags;
      OFS_WAKE: rdField = cfgWake;
      OFS_DUAL: rdField = cfgDual;
      default:  rdField = '0;
    endcase
  end

  assign busRdata = {{PAD_W{1'b0}}, rdField};
endmodule

// File: rtl/pin_irq_dp.sv
module pin_irq_dp
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS    = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] cfgMode,
  output logic [NUM_PINS-1:0] cfgPol,
  output logic [NUM_PINS-1:0] cfgEn,
  output logic [NUM_PINS-1:0] cfgWake,
  output logic [NUM_PINS-1:0] cfgDual,
  output logic [NUM_PINS-1:0] flags,
  output logic                irqOut,
  output logic                wakeOut
);
  logic [NUM_PINS-1:0] syncVal;
  logic [NUM_PINS-1:0] prevVal;
  logic [NUM_PINS-1:0] pinEvent;
  logic [NUM_PINS-1:0] clrMask;

  pin_irq_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .pinAsync(pinIn),
    .syncVal (syncVal),
    .prevVal (prevVal)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic riseHit, fallHit, levelHit, edgeHit;
    assign riseHit  = syncVal[i] & ~prevVal[i];
    assign fallHit  = ~syncVal[i] & prevVal[i];
    assign levelHit = syncVal[i] ^ cfgPol[i];
    assign edgeHit  = cfgDual[i] ? (riseHit | fallHit)
                                 : (cfgPol[i] ? fallHit : riseHit);
    assign pinEvent[i] = cfgMode[i] ? edgeHit : levelHit;
  end

  assign clrMask = strobe.wrClr ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgMode <= '0;
      cfgPol  <= '0;
      cfgEn   <= '0;
      cfgWake <= '0;
      cfgDual <= '0;
      flags   <= '0;
    end else begin
      if (strobe.wrMode) cfgMode <= wrData;
      if (strobe.wrPol)  cfgPol  <= wrData;
      if (strobe.wrEn)   cfgEn   <= wrData;
      if (strobe.wrWake) cfgWake <= wrData;
      if (strobe.wrDual) cfgDual <= wrData;
      flags <= (flags & ~clrMask) | pinEvent;
    end
  end

  assign irqOut  = |(flags & cfgEn);
  assign wakeOut = |(flags & cfgWake);

  assert_flag_drop_needs_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(flags) & ~flags)) |-> $past(strobe.wrClr));

  assert_irq_fall_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(strobe.wrClr || strobe.wrEn));

  assert_wake_fall_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wakeOut) |-> $past(strobe.wrClr || strobe.wrWake));

  assert_edge_needs_change_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|(flags & ~$past(flags) & $past(cfgMode))) |-> $past(syncVal != prevVal));

  assert_level_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(|($past(~cfgMode & (syncVal ^ cfgPol)) & ~flags)));
endmodule

// File: rtl/pin_irq_wake_ctrl.sv
module pin_irq_wake_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS    = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic                irqOut,
  output logic                wakeOut
);
  regStrobe_t          strobe;
  logic [NUM_PINS-1:0] wrData;
  logic [NUM_PINS-1:0] cfgMode, cfgPol, cfgEn, cfgWake, cfgDual, flags;

  pin_irq_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .cfgMode (cfgMode),
    .cfgPol  (cfgPol),
    .cfgEn   (cfgEn),
    .cfgWake (cfgWake),
    .cfgDual (cfgDual),
    .flags   (flags),
    .strobe  (strobe),
    .wrData  (wrData),
    .busRdata(busRdata)
  );

  pin_irq_dp #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .pinIn  (pinIn),
    .cfgMode(cfgMode),
    .cfgPol (cfgPol),
    .cfgEn  (cfgEn),
    .cfgWake(cfgWake),
    .cfgDual(cfgDual),
    .flags  (flags),
    .irqOut (irqOut),
    .wakeOut(wakeOut)
  );
endmodule

// File: tb/pin_irq_wake_ctrl_bench.sv
`timescale 1ns/1ps
module pin_irq_wake_ctrl_bench;
  localparam int NP = 14;
  localparam logic [31:0] ALL = 32'h3FFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NP-1:0] pinIn = '0;
  logic        irqOut, wakeOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  pin_irq_wake_ctrl u_pin_irq_wake_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .irqOut(irqOut), .wakeOut(wakeOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    regRead(a, d);
    check(req, d, exp);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] pat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readCheck("R1 mode", 8'h2C, 0);
    readCheck("R1 pol", 8'h30, 0);
    readCheck("R1 en", 8'h34, 0);
    readCheck("R1 flag", 8'h40, 0);
    readCheck("R1 wake", 8'h4C, 0);
    readCheck("R1 dual", 8'h5C, 0);
    check("R1 irq", {31'b0, irqOut}, 0);
    check("R1 wake", {31'b0, wakeOut}, 0);

    // R2: map and reserved bits
    regWrite(8'h34, 32'hFFFF_FFFF); readCheck("R2 en", 8'h34, ALL);
    regWrite(8'h4C, 32'hFFFF_C001); readCheck("R2 wake", 8'h4C, 32'h1);
    regWrite(8'h5C, 32'h0000_2AAA); readCheck("R2 dual", 8'h5C, 32'h2AAA);
    regWrite(8'h30, 32'hABCD_1555); readCheck("R2 pol", 8'h30, 32'h1555);
    regWrite(8'h2C, 32'hFFFF_FFFF); readCheck("R2 mode", 8'h2C, ALL);
    readCheck("R4 clr reads zero", 8'h48, 0);
    regWrite(8'h34, 0); regWrite(8'h4C, 0); regWrite(8'h5C, 0); regWrite(8'h30, 0);
    regWrite(8'h2C, 0);

    // Sweep: all mode/pol/dual combinations, every pin, both transitions
    for (int m = 0; m < 2; m++)
      for (int q = 0; q < 2; q++)
        for (int dl = 0; dl < 2; dl++)
          for (int p = 0; p < NP; p++) begin
            logic s, nv, fired1, fired2;
            s = (m == 0) ? q[0] : p[0];
            nv = ~s;
            regWrite(8'h2C, m ? ALL : 0);
            regWrite(8'h30, q ? ALL : 0);
            regWrite(8'h5C, dl ? ALL : 0);
            @(negedge clk); pinIn = {NP{s}};
            settle(4);
            regWrite(8'h48, ALL);
            readCheck("R4 cleared idle", 8'h40, 0);
            @(negedge clk); pinIn[p] = nv;
            settle(2);
            readCheck("R12 not yet", 8'h40, 0);
            if (m == 0) fired1 = 1'b1;
            else fired1 = dl ? 1'b1 : (q ? ~nv : nv);
            settle(1);
            readCheck(m ? (dl ? "R7 dual first" : "R6 first edge") : "R8 level set",
                      8'h40, fired1 ? (32'h1 << p) : 0);
            if (m == 0) begin
              regWrite(8'h48, ALL);
              readCheck("R5 set beats clear", 8'h40, 32'h1 << p);
              @(negedge clk); pinIn[p] = s;
              settle(4);
              regWrite(8'h48, ALL);
              readCheck("R8 level gone", 8'h40, 0);
            end else begin
              regWrite(8'h48, ALL);
              @(negedge clk); pinIn[p] = s;
              settle(4);
              fired2 = dl ? 1'b1 : (q ? ~s : s);
              readCheck(dl ? "R7 dual second" : "R6 second edge", 8'h40,
                        fired2 ? (32'h1 << p) : 0);
            end
          end

    // Enable / wake reductions on a fixed flag pattern
    regWrite(8'h2C, ALL); regWrite(8'h30, 0); regWrite(8'h5C, 0);
    @(negedge clk); pinIn = '0;
    settle(4);
    regWrite(8'h48, ALL);
    pat = 32'h2A5C;
    @(negedge clk); pinIn = pat[NP-1:0];
    settle(4);
    readCheck("R9 flags set with enable off", 8'h40, pat);
    for (int k = 0; k < NP; k++) begin
      regWrite(8'h34, 32'h1 << k);
      check("R10 irq onehot", {31'b0, irqOut}, {31'b0, pat[k]});
      check("R11 wake idle", {31'b0, wakeOut}, 0);
    end
    regWrite(8'h34, 0);
    for (int k = 0; k < NP; k++) begin
      regWrite(8'h4C, 32'h1 << k);
      check("R11 wake onehot", {31'b0, wakeOut}, {31'b0, pat[k]});
      check("R10 irq idle", {31'b0, irqOut}, 0);
    end
    regWrite(8'h34, ALL);
    check("R10 irq all", {31'b0, irqOut}, 1);
    regWrite(8'h34, 0);
    check("R10 irq off", {31'b0, irqOut}, 0);
    readCheck("R9 flags kept", 8'h40, pat);
    regWrite(8'h48, 0);
    readCheck("R4 zero write", 8'h40, pat);
    regWrite(8'h40, 0);
    readCheck("R3 read only", 8'h40, pat);
    regWrite(8'h4C, ALL);
    regWrite(8'h48, 32'h0A0C);
    readCheck("R4 partial", 8'h40, pat & ~32'h0A0C);
    check("R11 wake on", {31'b0, wakeOut}, 1);
    regWrite(8'h48, ALL);
    readCheck("R4 full", 8'h40, 0);
    check("R11 wake off", {31'b0, wakeOut}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule